// File: doc/BRIEF.md
# Dual SD Card SPI Master

This block is a byte-wide SPI master through which a processor reaches two SD cards. The two cards share one serial clock and both data lines, and each card has its own active-low chip select. Software writes a byte to the data register to clock out eight bits. While those bits go out, the block collects eight bits from the card. When the status register shows the block idle again, software reads the received byte from the data register. SD command framing, CRC generation and response parsing are left to software.

A control register chooses which card is addressed, whether its select is driven, and whether the serial clock runs at the slow rate used during card initialization or at the fast rate used for data. Control writes always land in a request register. The block copies that request into the active configuration only while no byte is in flight, so neither the clock rate nor the selects can change in the middle of a byte. Each card also has an active-low card-detect input. It passes through a two-flop synchronizer and a debounce filter, and the filtered result appears in the status register.

The serial engine is a three-state machine. `XF_IDLE` holds SCK low and, when a data write arrives, goes to `XF_LEAD`. `XF_LEAD` is the SCK-low half-bit. When its divider tick arrives, SCK rises, MISO is sampled and the machine goes to `XF_TRAIL`. `XF_TRAIL` is the SCK-high half-bit. When its tick arrives, SCK falls. The machine then returns to `XF_LEAD` with the next MOSI bit, or to `XF_IDLE` after the eighth bit. Each half-bit lasts SLOW_HALF or FAST_HALF clock cycles. With a 50 MHz system clock, the default values give about 397 kHz and about 1.9 MHz.

Top module: `sd_spi_dual`

## Requirements
- R1: After reset, both `cs_n` bits are high, `sck` is low and the status register reads 00h.
- R2: A write to address 0 while idle sends that byte on `mosi`, most significant bit first, in SPI mode 0. SCK idles low, exactly eight rising edges are produced, and MOSI is stable at each rising edge.
- R3: MISO is sampled at each SCK rising edge, most significant bit first. After busy clears, reading address 0 returns the eight sampled bits.
- R4: Status bit 0 (busy) is 1 from the cycle after the starting write until the eighth SCK falling edge. A write to address 0 while busy is ignored.
- R5: The SCK period is 2*SLOW_HALF clock cycles when control bit 2 is 0 and 2*FAST_HALF when it is 1. SCK is low whenever the block is idle.
- R6: Control register (address 1 write) fields are: bit 0 card index, bit 1 select enable, bit 2 fast clock. With bit 1 set, `cs_n[index]` is low and the other select is high. With bit 1 clear, both selects are high. The two selects are never low together.
- R7: A control write made during a transfer changes neither the clock rate nor the selects of that byte. It takes effect from the next byte.
- R8: `cd_n[i]` low means card i is present. Status bit 1 reports card 0 and status bit 2 reports card 1, after synchronization and a debounce of DEBOUNCE_CYCLES. A level change shorter than that window is not reported.
- R9: Writing FFh with select enable clear produces eight SCK pulses with MOSI high and both selects high. Repeating the write yields the 74 or more power-up clocks a card needs.
- R10: Status read (address 1) bit 3 shows the active clock speed, bit 4 the active select enable and bit 5 the active card index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = data, 1 = control (write) / status (read) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| sck | output | 1 | Shared serial clock |
| mosi | output | 1 | Shared serial data to the cards |
| miso | input | 1 | Shared serial data from the cards |
| cs_n | output | 2 | Per-card active-low chip selects |
| cd_n | input | 2 | Per-card active-low card-detect |

## Verification
The bench switches to the fast clock and retargets the select in the middle of a slow byte. A design that applied control writes at once would show a short SCK period or a select edge inside that byte. A second data write during a transfer must neither restart the shifter nor add clocks, so a design without the busy guard would show more than eight rising edges or a corrupted byte. The bench sends card-detect glitches shorter than the debounce window, and a design missing the filter would report them as card insertions. Dummy-clock bursts check that MOSI stays high with both selects off. Complementary MOSI/MISO patterns catch bit-order or sampling-edge errors.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_LEAD,
        XF_TRAIL
    } xfer_state_t;

    typedef struct packed {
        logic fast;
        logic sel_en;
        logic card;
    } spi_ctrl_t;

endpackage

// File: rtl/sd_spi_clkdiv.sv
module sd_spi_clkdiv #(
    parameter int SLOW_HALF = 63,
    parameter int FAST_HALF = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW   = $clog2(MAXH + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
        tick  = run && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sd_spi_shift.sv
module sd_spi_shift
    import sd_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic [7:0] rx_byte
);
    xfer_state_t state, state_nx;
    logic [7:0]  tx_sr;
    logic [7:0]  rx_sr;
    logic [2:0]  bit_cnt;
    logic        sck_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= XF_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE:  if (start) state_nx = XF_LEAD;
            XF_LEAD:  if (tick)  state_nx = XF_TRAIL;
            XF_TRAIL: if (tick)  state_nx = (bit_cnt == 3'd7) ? XF_IDLE : XF_LEAD;
            default:  state_nx = XF_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= 8'hFF;
            rx_sr   <= 8'h00;
            bit_cnt <= 3'd0;
            sck_q   <= 1'b0;
        end else begin
            unique case (state)
                XF_IDLE: begin
                    sck_q <= 1'b0;
                    if (start) begin
                        tx_sr   <= tx_byte;
                        bit_cnt <= 3'd0;
                    end
                end
                XF_LEAD: begin
                    if (tick) begin
                        sck_q <= 1'b1;
                        rx_sr <= {rx_sr[6:0], miso};
                    end
                end
                XF_TRAIL: begin
                    if (tick) begin
                        sck_q   <= 1'b0;
                        tx_sr   <= {tx_sr[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                end
                default: sck_q <= 1'b0;
            endcase
        end
    end

    assign sck     = sck_q;
    assign mosi    = tx_sr[7];
    assign busy    = (state != XF_IDLE);
    assign rx_byte = rx_sr;
endmodule

// File: rtl/sd_cd_filter.sv
module sd_cd_filter #(
    parameter int DEBOUNCE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_n,
    output logic present
);
    localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [DW-1:0] cnt;
    logic          raw;

    assign raw = ~sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            cnt     <= '0;
            present <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], cd_n};
            if (raw == present)
                cnt <= '0;
            else if (cnt == DW'(DEBOUNCE_CYCLES - 1)) begin
                present <= raw;
                cnt     <= '0;
            end else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sd_spi_dual.sv
module sd_spi_dual
    import sd_spi_pkg::*;
#(
    parameter int SLOW_HALF       = 63,
    parameter int FAST_HALF       = 13,
    parameter int DEBOUNCE_CYCLES = 250000,
    parameter int NUM_CARDS       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       sck,
    output logic       mosi,
    input  logic       miso,
    output logic [1:0] cs_n,
    input  logic [1:0] cd_n
);
    spi_ctrl_t      ctrl_req, ctrl_act;
    logic           busy, tick, start;
    logic [7:0]     rx_byte;
    logic [NUM_CARDS-1:0] present;

    assign start = wr_en && !addr && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_req <= '0;
            ctrl_act <= '0;
        end else begin
            if (wr_en && addr)
                ctrl_req <= spi_ctrl_t'(wr_data[2:0]);
            if (!busy)
                ctrl_act <= ctrl_req;
        end
    end

    sd_spi_clkdiv #(
        .SLOW_HALF(SLOW_HALF),
        .FAST_HALF(FAST_HALF)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .fast (ctrl_act.fast),
        .tick (tick)
    );

    sd_spi_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tx_byte(wr_data),
        .tick   (tick),
        .miso   (miso),
        .sck    (sck),
        .mosi   (mosi),
        .busy   (busy),
        .rx_byte(rx_byte)
    );

    for (genvar i = 0; i < NUM_CARDS; i++) begin : g_card
        sd_cd_filter #(
            .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
        ) u_cd (
            .clk    (clk),
            .rst_n  (rst_n),
            .cd_n   (cd_n[i]),
            .present(present[i])
        );
        assign cs_n[i] = !(ctrl_act.sel_en && (ctrl_act.card == 1'(i)));
    end

    always_comb begin
        if (addr)
            rd_data = {2'b00, ctrl_act.card, ctrl_act.sel_en, ctrl_act.fast,
                       present[1], present[0], busy};
        else
            rd_data = rx_byte;
    end
endmodule

// File: rtl/sd_spi_dual_chk.sv
module sd_spi_dual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       addr,
    input logic       busy,
    input logic       sck,
    input logic [1:0] cs_n
);
    // R6
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R5
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R7
    cs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));

    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && !addr));

    // R2
    end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !sck);
endmodule

bind sd_spi_dual sd_spi_dual_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .addr (addr),
    .busy (busy),
    .sck  (sck),
    .cs_n (cs_n)
);

// File: tb/sd_spi_dual_tb.sv
module sd_spi_dual_tb;
    localparam int SH  = 10;
    localparam int FH  = 3;
    localparam int DEB = 40;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic       addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       sck, mosi, miso;
    logic [1:0] cs_n;
    logic [1:0] cd_n = 2'b11;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    sd_spi_dual #(
        .SLOW_HALF(SH), .FAST_HALF(FH), .DEBOUNCE_CYCLES(DEB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .cd_n(cd_n)
    );

    // card model
    logic [7:0] sl_tx = 0, sl_rx = 0;
    logic [1:0] cs_first = 2'b11;
    int  rises = 0, last_rise = 0, pmin = 0, pmax = 0;
    bit  cs_changed = 0, mosi_zero = 0, both_low = 0;
    assign miso = sl_tx[7];

    always @(posedge sck) begin
        if (rises > 0) begin
            if (cyc - last_rise < pmin) pmin = cyc - last_rise;
            if (cyc - last_rise > pmax) pmax = cyc - last_rise;
        end else
            cs_first = cs_n;
        if (cs_n != cs_first) cs_changed = 1;
        if (!mosi) mosi_zero = 1;
        last_rise = cyc;
        rises++;
        sl_rx = {sl_rx[6:0], mosi};
    end
    always @(negedge sck) sl_tx = {sl_tx[6:0], 1'b0};
    always @(negedge clk) if (cs_n == 2'b00) both_low = 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; addr = 0;
    endtask

    task automatic cpu_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
        addr = 0;
    endtask

    task automatic clear_mon();
        rises = 0; pmin = 1000; pmax = 0; cs_changed = 0; mosi_zero = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            cpu_read(1, s);
            if (!s[0]) break;
        end
    endtask

    // {ctrl[2:0], tx, card reply, expected cs_n}
    localparam logic [20:0] VEC [6] = '{
        {3'b010, 8'h40, 8'h01, 2'b10},
        {3'b011, 8'hA5, 8'h5A, 2'b01},
        {3'b110, 8'h3C, 8'hC3, 2'b10},
        {3'b111, 8'h00, 8'hFF, 2'b01},
        {3'b100, 8'hFF, 8'h81, 2'b11},
        {3'b000, 8'h96, 8'h69, 2'b11}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        cpu_read(1, v);
        check("R1 status", v, 8'h00);
        check("R1 cs_n", cs_n, 2'b11);
        check("R1 sck", sck, 0);

        // table walk: R2 R3 R5 R6 R10
        foreach (VEC[k]) begin
            logic [2:0] c;
            logic [7:0] tx, rp;
            logic [1:0] ecs;
            {c, tx, rp, ecs} = VEC[k];
            cpu_write(1, {5'b0, c});
            repeat (2) @(negedge clk);
            cpu_read(1, v);
            check("R10 active ctrl", v[5:3], {c[0], c[1], c[2]});
            check("R6 cs_n idle", cs_n, ecs);
            clear_mon();
            sl_tx = rp;
            cpu_write(0, tx);
            wait_idle();
            check("R2 rising edges", rises, 8);
            check("R2 mosi bits", sl_rx, tx);
            cpu_read(0, v);
            check("R3 rx byte", v, rp);
            check("R6 cs_n during", cs_first, ecs);
            check("R5 period max", pmax, c[2] ? 2*FH : 2*SH);
            check("R5 period min", pmin, c[2] ? 2*FH : 2*SH);
            check("R5 idle sck", sck, 0);
        end

        // R4 busy and ignored write
        cpu_write(1, 8'h02);
        repeat (2) @(negedge clk);
        clear_mon();
        sl_tx = 8'hAA;
        cpu_write(0, 8'h12);
        cpu_read(1, v);
        check("R4 busy set", v[0], 1);
        repeat (3*SH) @(negedge clk);
        cpu_write(0, 8'h34);
        wait_idle();
        repeat (50) @(negedge clk);
        check("R4 no restart edges", rises, 8);
        check("R4 byte kept", sl_rx, 8'h12);
        cpu_read(0, v);
        check("R4 rx", v, 8'hAA);

        // R7 control change mid-byte
        clear_mon();
        sl_tx = 8'h0F;
        cpu_write(0, 8'hC8);
        repeat (3*SH) @(negedge clk);
        cpu_write(1, 8'h07);
        wait_idle();
        check("R7 slow kept", pmax, 2*SH);
        check("R7 cs kept", cs_first, 2'b10);
        check("R7 cs stable", cs_changed, 0);
        repeat (2) @(negedge clk);
        clear_mon();
        cpu_write(0, 8'h55);
        wait_idle();
        check("R7 fast next", pmax, 2*FH);
        check("R7 cs next", cs_first, 2'b01);

        // R9 dummy clocks
        cpu_write(1, 8'h00);
        repeat (2) @(negedge clk);
        clear_mon();
        for (int n = 0; n < 10; n++) begin
            cpu_write(0, 8'hFF);
            wait_idle();
        end
        check("R9 clock count", rises, 80);
        check("R9 mosi high", mosi_zero, 0);
        check("R9 cs high", cs_first, 2'b11);
        check("R9 cs stayed", cs_changed, 0);

        // R8 card detect
        cd_n[0] = 0;
        repeat (DEB + 10) @(negedge clk);
        cpu_read(1, v);
        check("R8 card0 present", v[2:1], 2'b01);
        cd_n[1] = 0;
        repeat (DEB / 2) @(negedge clk);
        cd_n[1] = 1;
        repeat (DEB + 10) @(negedge clk);
        cpu_read(1, v);
        check("R8 glitch ignored", v[2:1], 2'b01);
        cd_n[1] = 0;
        repeat (DEB + 10) @(negedge clk);
        cpu_read(1, v);
        check("R8 card1 present", v[2:1], 2'b11);
        cd_n[0] = 1;
        repeat (DEB + 10) @(negedge clk);
        cpu_read(1, v);
        check("R8 card0 removed", v[2:1], 2'b10);

        check("R6 never both low", both_low, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule